// File: doc/BRIEF.md
# Way Lock and Replacement Selector

This block picks the way to replace when a request misses in an eight-way set. It gets the lock bits read from the indexed set, the mask of ways the requester may use, and a candidate from a separate replacement policy. From these it works out which ways are free to evict and names one of them as the victim. A miss can also ask to pin its line. The block then tells the tag pipeline whether to set the lock bit of the chosen way.

Two rules keep the set usable. First, a lock is refused when the chosen way is the requester's only unlocked way. The fill still happens, but the line is not pinned. Second, when every way the requester may use is already locked, the lowest-numbered allowed way is evicted anyway and its lock is dropped. Each rule sets its own sticky error flag, and each flag has its own interrupt enable.

The choice is made combinationally. It is presented one clock after the request, under a valid strobe, together with lock set and lock clear commands for the tag update.

Top module: `way_lock_victim`

## Requirements
- R1: After reset, out_valid, out_lock_set, out_lock_clr, err_last, err_none and irq are all 0.
- R2: Bit i of lock_bits and of allow_mask refers to way i. A way is available when it is allowed and its lock bit is 0. When the base candidate base_way is available, out_way equals base_way.
- R3: When base_way is not available but some way is, out_way is the lowest-numbered available way. A locked way is never the victim while any allowed way is unlocked.
- R4: An allow_mask of all zeros behaves exactly like a mask with every way allowed.
- R5: When no allowed way is unlocked, out_way is the lowest-numbered allowed way and out_lock_clr is 1. err_none becomes 1 on the same edge.
- R6: A lock request (req_lock=1) that has two or more available ways gives out_lock_set=1 for the chosen way and raises no error.
- R7: A lock request with exactly one available way picks that way with out_lock_set=0 and sets err_last. A lock request with no available way follows R5 and does not set err_last.
- R8: out_valid is 1 exactly in the cycle after a cycle with req_valid=1. out_lock_set and out_lock_clr are 0 whenever out_valid is 0.
- R9: err_last and err_none stay set until a 1 is written on clr_last or clr_none. A set event wins over a clear in the same cycle.
- R10: irq equals (err_last AND irq_en_last) OR (err_none AND irq_en_none). The enables do not affect the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_lock | input | 1 | Request asks to pin its line |
| lock_bits | input | NUM_WAYS | Lock bit per way at the index |
| allow_mask | input | NUM_WAYS | Ways the requester may use (0 = all) |
| base_way | input | WAY_W | Candidate from the base replacement policy |
| irq_en_last | input | 1 | Interrupt enable for refused-lock flag |
| irq_en_none | input | 1 | Interrupt enable for no-free-way flag |
| clr_last | input | 1 | Write-one-to-clear strobe for err_last |
| clr_none | input | 1 | Write-one-to-clear strobe for err_none |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_way | output | WAY_W | Selected victim way |
| out_lock_set | output | 1 | Set lock bit of out_way |
| out_lock_clr | output | 1 | Clear lock bit of out_way |
| err_last | output | 1 | Sticky: lock on last available way refused |
| err_none | output | 1 | Sticky: no allowed unlocked way on a miss |
| irq | output | 1 | Enabled error interrupt |

## Verification
The selector is driven with lock and mask combinations built to separate its three paths. In one the base candidate is free and is kept. In another it is locked or outside the mask, so the lowest free way wins, which shows the chain runs from the low end rather than the high end. In the last every allowed way is locked, so the fallback and lock clear apply. An empty mask is run beside an all-ones mask, which checks that the zero case is expanded and not treated as "nothing allowed". Lock requests are sent with two free ways, with one free way (the two-way mask example) and with none, which separates the refusal from the fallback. Flag runs cover stickiness, clearing, the set-over-clear collision and each interrupt enable on its own.

// File: rtl/way_lock_pkg.sv
package way_lock_pkg;
   // How the victim was chosen
   typedef enum logic [1:0] {
      PICK_BASE     = 2'd0,
      PICK_LOWEST   = 2'd1,
      PICK_FALLBACK = 2'd2
   } pick_kind_e;

   localparam int unsigned FLAG_LAST = 0;
   localparam int unsigned FLAG_NONE = 1;
   localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/wl_lowest.sv
module wl_lowest #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDX_W-1:0] idx,
   output logic             found
);
   // scan from the top so the lowest set bit is written last
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wl_select.sv
module wl_select
   import way_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] lock_bits,
   input  logic [NUM_WAYS-1:0] allow_mask,
   input  logic [WAY_W-1:0]    base_way,
   output logic [WAY_W-1:0]    way,
   output pick_kind_e          kind,
   output logic                any_avail,
   output logic                multi_avail
);
   logic [NUM_WAYS-1:0] eff_allow;
   logic [NUM_WAYS-1:0] avail;
   logic [WAY_W-1:0]    low_avail_idx;
   logic [WAY_W-1:0]    low_allow_idx;
   logic                low_allow_found;
   logic                base_ok;

   // an empty mask means the requester has no restriction
   assign eff_allow = (allow_mask == '0) ? '1 : allow_mask;

   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_avail
      assign avail[g] = eff_allow[g] & ~lock_bits[g];
   end

   wl_lowest #(.WIDTH(NUM_WAYS)) u_low_avail (
      .vec   (avail),
      .idx   (low_avail_idx),
      .found (any_avail)
   );

   wl_lowest #(.WIDTH(NUM_WAYS)) u_low_allow (
      .vec   (eff_allow),
      .idx   (low_allow_idx),
      .found (low_allow_found)
   );

   // clearing the lowest set bit leaves something only if two or more were set
   assign multi_avail = |(avail & (avail - NUM_WAYS'(1)));
   assign base_ok     = avail[base_way];

   always_comb begin
      if (base_ok) begin
         way  = base_way;
         kind = PICK_BASE;
      end else if (any_avail) begin
         way  = low_avail_idx;
         kind = PICK_LOWEST;
      end else begin
         way  = low_allow_found ? low_allow_idx : '0;
         kind = PICK_FALLBACK;
      end
   end
endmodule

// File: rtl/wl_flags.sv
module wl_flags #(
   parameter int unsigned COUNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [COUNT-1:0] set_evt,
   input  logic [COUNT-1:0] clr_req,
   input  logic [COUNT-1:0] irq_en,
   output logic [COUNT-1:0] flags,
   output logic             irq
);
   for (genvar g = 0; g < COUNT; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[g] <= 1'b0;
         else if (set_evt[g]) flags[g] <= 1'b1;   // set beats clear
         else if (clr_req[g]) flags[g] <= 1'b0;
      end
   end

   assign irq = |(flags & irq_en);
endmodule

// File: rtl/way_lock_victim.sv
module way_lock_victim
   import way_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_lock,
   input  logic [NUM_WAYS-1:0] lock_bits,
   input  logic [NUM_WAYS-1:0] allow_mask,
   input  logic [WAY_W-1:0]    base_way,
   input  logic                irq_en_last,
   input  logic                irq_en_none,
   input  logic                clr_last,
   input  logic                clr_none,
   output logic                out_valid,
   output logic [WAY_W-1:0]    out_way,
   output logic                out_lock_set,
   output logic                out_lock_clr,
   output logic                err_last,
   output logic                err_none,
   output logic                irq
);
   if (NUM_WAYS < 2 || (1 << WAY_W) != NUM_WAYS) begin : g_bad_ways
      $error("way_lock_victim: NUM_WAYS must be a power of two of at least 2");
   end

   logic [WAY_W-1:0]     sel_way;
   pick_kind_e           sel_kind;
   logic                 sel_any;
   logic                 sel_multi;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_clr;
   logic [NUM_FLAGS-1:0] flag_en;
   logic [NUM_FLAGS-1:0] flag_q;

   wl_select #(.NUM_WAYS(NUM_WAYS)) u_select (
      .lock_bits   (lock_bits),
      .allow_mask  (allow_mask),
      .base_way    (base_way),
      .way         (sel_way),
      .kind        (sel_kind),
      .any_avail   (sel_any),
      .multi_avail (sel_multi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_way      <= '0;
         out_lock_set <= 1'b0;
         out_lock_clr <= 1'b0;
      end else begin
         out_valid    <= req_valid;
         out_lock_set <= req_valid & req_lock & sel_multi;
         out_lock_clr <= req_valid & (sel_kind == PICK_FALLBACK);
         if (req_valid) out_way <= sel_way;
      end
   end

   assign flag_set[FLAG_LAST] = req_valid & req_lock & sel_any & ~sel_multi;
   assign flag_set[FLAG_NONE] = req_valid & (sel_kind == PICK_FALLBACK);
   assign flag_clr[FLAG_LAST] = clr_last;
   assign flag_clr[FLAG_NONE] = clr_none;
   assign flag_en[FLAG_LAST]  = irq_en_last;
   assign flag_en[FLAG_NONE]  = irq_en_none;

   wl_flags #(.COUNT(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (flag_set),
      .clr_req (flag_clr),
      .irq_en  (flag_en),
      .flags   (flag_q),
      .irq     (irq)
   );

   assign err_last = flag_q[FLAG_LAST];
   assign err_none = flag_q[FLAG_NONE];
endmodule

// File: rtl/way_lock_victim_chk.sv
module way_lock_victim_chk #(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_lock,
   input logic [NUM_WAYS-1:0] lock_bits,
   input logic [NUM_WAYS-1:0] allow_mask,
   input logic [WAY_W-1:0]    base_way,
   input logic                irq_en_last,
   input logic                irq_en_none,
   input logic                clr_last,
   input logic                clr_none,
   input logic                out_valid,
   input logic [WAY_W-1:0]    out_way,
   input logic                out_lock_set,
   input logic                out_lock_clr,
   input logic                err_last,
   input logic                err_none,
   input logic                irq
);
   logic [NUM_WAYS-1:0] free_q;
   logic                base_free_q;
   logic [WAY_W-1:0]    base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q      <= '0;
         base_free_q <= 1'b0;
         base_q      <= '0;
      end else if (req_valid) begin
         free_q      <= ((allow_mask == '0) ? {NUM_WAYS{1'b1}} : allow_mask) & ~lock_bits;
         base_free_q <= ((allow_mask == '0) || allow_mask[base_way]) && !lock_bits[base_way];
         base_q      <= base_way;
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);                                          // R8
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);                                        // R8
   AST_CMD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (out_lock_set || out_lock_clr) |-> out_valid);                     // R8
   AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && base_free_q) |-> (out_way == base_q));               // R2
   AST_NO_LOCKED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (free_q != '0)) |-> free_q[out_way]);                // R3
   AST_FALLBACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (free_q == '0)) |-> (out_lock_clr && err_none));     // R5
   AST_LOCK_NEEDS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
      out_lock_set |-> ($countones(free_q) >= 2));                       // R7
   AST_STICKY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (err_last && !clr_last) |=> err_last);                             // R9
   AST_STICKY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_none && !clr_none) |=> err_none);                             // R9
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((err_last && irq_en_last) || (err_none && irq_en_none))); // R10
   AST_SET_STRADDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lock && $countones(((allow_mask == '0) ? {NUM_WAYS{1'b1}} : allow_mask) & ~lock_bits) == 1)
      |=> err_last);                                                     // R7
endmodule

bind way_lock_victim way_lock_victim_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/way_lock_victim_test.sv
module way_lock_victim_test;
   localparam int CLK_P = 10;
   localparam int NW    = 8;
   localparam int WW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_lock = 1'b0;
   logic [NW-1:0] lock_bits = '0;
   logic [NW-1:0] allow_mask = '0;
   logic [WW-1:0] base_way = '0;
   logic          irq_en_last = 1'b0;
   logic          irq_en_none = 1'b0;
   logic          clr_last = 1'b0;
   logic          clr_none = 1'b0;
   logic          out_valid;
   logic [WW-1:0] out_way;
   logic          out_lock_set;
   logic          out_lock_clr;
   logic          err_last;
   logic          err_none;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_P/2) clk = ~clk;

   way_lock_victim #(.NUM_WAYS(NW)) uut (.*);

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one request cycle; returns with registered outputs settled
   task automatic do_req(input logic lk, input logic [NW-1:0] locks,
                         input logic [NW-1:0] allow, input logic [WW-1:0] base);
      @(negedge clk);
      req_valid = 1'b1; req_lock = lk;
      lock_bits = locks; allow_mask = allow; base_way = base;
      @(negedge clk);
      req_valid = 1'b0; req_lock = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk);
      clr_last = 1'b1; clr_none = 1'b1;
      @(negedge clk);
      clr_last = 1'b0; clr_none = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 out_valid", out_valid, 0);
      check("R1 out_lock_set", out_lock_set, 0);
      check("R1 out_lock_clr", out_lock_clr, 0);
      check("R1 err_last", err_last, 0);
      check("R1 err_none", err_none, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_base_kept();
      do_req(1'b0, 8'h00, 8'hFF, 3'd5);
      check("R2 base free way", out_way, 5);
      check("R8 valid after req", out_valid, 1);
      check("R2 no lock cmd", out_lock_set, 0);
      @(negedge clk);
      check("R8 valid drops", out_valid, 0);
      check("R8 clr cmd low when idle", out_lock_clr, 0);
   endtask

   task automatic t_lowest_free();
      do_req(1'b0, 8'h20, 8'hF0, 3'd5);   // base locked, free = 0xD0
      check("R3 base locked -> lowest free", out_way, 4);
      do_req(1'b0, 8'h00, 8'h0C, 3'd1);   // base not allowed
      check("R3 base disallowed -> lowest allowed", out_way, 2);
      do_req(1'b0, 8'h7F, 8'hFF, 3'd0);   // only way 7 free
      check("R3 only high way free", out_way, 7);
      check("R3 no fallback", out_lock_clr, 0);
   endtask

   task automatic t_zero_mask();
      do_req(1'b0, 8'h0F, 8'h00, 3'd0);
      check("R4 empty mask base locked", out_way, 4);
      do_req(1'b0, 8'h0F, 8'h00, 3'd7);
      check("R4 empty mask base free", out_way, 7);
      check("R4 no fallback", err_none, 0);
   endtask

   task automatic t_fallback();
      do_req(1'b0, 8'h0C, 8'h0C, 3'd3);
      check("R5 fallback lowest allowed", out_way, 2);
      check("R5 lock clear", out_lock_clr, 1);
      check("R5 err_none", err_none, 1);
      check("R5 err_last untouched", err_last, 0);
      clear_flags();
      do_req(1'b1, 8'hFF, 8'h00, 3'd6);   // lock req, nothing free
      check("R7 lock none -> way 0", out_way, 0);
      check("R7 lock none no set", out_lock_set, 0);
      check("R7 lock none no err_last", err_last, 0);
      check("R5 lock none err_none", err_none, 1);
      clear_flags();
   endtask

   task automatic t_lock_ok();
      do_req(1'b1, 8'h00, 8'h03, 3'd1);
      check("R6 lock way", out_way, 1);
      check("R6 lock set", out_lock_set, 1);
      check("R6 no err_last", err_last, 0);
   endtask

   task automatic t_lock_last();
      do_req(1'b1, 8'h02, 8'h03, 3'd1);   // only way 0 left
      check("R7 last way chosen", out_way, 0);
      check("R7 lock refused", out_lock_set, 0);
      check("R7 err_last", err_last, 1);
      check("R7 no clear cmd", out_lock_clr, 0);
   endtask

   task automatic t_flags();
      // err_last is set from t_lock_last
      check("R10 irq off when disabled", irq, 0);
      @(negedge clk); irq_en_last = 1'b1; #1;
      check("R10 irq with enable", irq, 1);
      @(negedge clk); irq_en_last = 1'b0; #1;
      check("R10 enable does not clear flag", err_last, 1);
      @(negedge clk);
      check("R9 sticky", err_last, 1);
      clear_flags();
      check("R9 cleared", err_last, 0);
      // set and clear in same cycle
      @(negedge clk);
      req_valid = 1'b1; req_lock = 1'b1;
      lock_bits = 8'h02; allow_mask = 8'h03; base_way = 3'd0;
      clr_last = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_lock = 1'b0; clr_last = 1'b0;
      check("R9 set beats clear", err_last, 1);
      do_req(1'b0, 8'h0C, 8'h0C, 3'd2);
      irq_en_none = 1'b1; #1;
      check("R10 irq from err_none", irq, 1);
      irq_en_none = 1'b0; #1;
      check("R10 irq none disabled", irq, 0);
      clear_flags();
   endtask

   initial begin
      #(CLK_P * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_base_kept();
      t_lowest_free();
      t_zero_mask();
      t_fallback();
      t_lock_ok();
      t_lock_last();
      t_flags();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule